// File: doc/BRIEF.md
# Tributary Input Monitor and AIS Inserter

This block sits at the transmit entry of one DS1/E1 tributary. Everything runs on a free-running reference clock. The tributary clock and data pins are brought into that domain through a short synchronizer. A per-tributary setting chooses which tributary clock edge captures each data bit, and each captured bit leaves the block with a one-cycle strobe.

The block also watches the tributary for two alarm conditions.

- **Loss of clock.** The block counts reference cycles in which no tributary clock transition appears. Too long a gap raises the alarm.
- **Loss of frame sync.** In byte-synchronous mode, the block compares the arrival time of each frame pulse against a flywheel that expects one pulse per frame period. Three consecutive valid pulses acquire frame. Six consecutive mismatches lose it.

Each alarm has a level status output and a sticky change flag. The change flags are cleared by a write-one-to-clear strobe and can be masked away from a single interrupt output.

The block drives a two-bit selection code to the downstream VT builder. That code asks for either an all-ones payload inside a valid VT, or an all-ones fill of the entire VT including its V1 to V4 bytes.

Top module: `trib_input_monitor`

## Requirements
- R1: With `cfg_rise_edge` = 1 each bit is captured on a rising tributary clock edge, with 0 on a falling edge; every capture produces exactly one `rt_valid` pulse carrying the data level present at that edge, and the other edge captures nothing.
- R2: `loc_status` rises after LOC_LIMIT (default 16) consecutive reference cycles in which no tributary clock transition of either polarity is seen, and falls on the first transition seen again.
- R3: `alarm_delta` bit 0 (clock loss) and bit 1 (frame sync loss) are set whenever the matching status output changes in either direction, stay set until a cycle with the same bit of `alarm_clr` high, and a new change wins over a clear in the same cycle.
- R4: `irq` is high exactly when some `alarm_delta` bit is set whose `alarm_mask` bit (same positions as R3) is 0; a mask bit of 1 removes that flag from the interrupt.
- R5: When `cfg_byte_sync` is 0 the frame monitor is idle: `lofs_status` drops to 0 and frame pulses have no effect on it.
- R6: A frame pulse is valid when it arrives exactly FRAME_TICKS reference cycles after the previous pulse; a pulse at any other spacing, or no pulse when one is due, is a mismatch, and a valid pulse clears the mismatch run while a mismatch clears the valid run.
- R7: `lofs_status` falls when the third consecutive valid pulse arrives; two in a row are not enough.
- R8: `lofs_status` rises on the sixth consecutive mismatch; five in a row are not enough.
- R9: `ais_sel` reads 2'b00 with no alarm, 2'b01 (all-ones payload in a valid VT) while only `loc_status` is high, and 2'b10 (all-ones full VT) whenever `lofs_status` is high, which takes priority over clock loss.
- R10: After reset `rt_valid`, both status bits, `alarm_delta` and `irq` are 0 and `ais_sel` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rise_edge | input | 1 | 1: capture on rising tributary edge, 0: falling |
| cfg_byte_sync | input | 1 | Enables frame-sync monitoring |
| trib_clk | input | 1 | Tributary clock, asynchronous to `clk` |
| trib_data | input | 1 | Tributary serial data |
| trib_fs | input | 1 | One-cycle frame pulse in the reference domain |
| alarm_mask | input | 2 | Interrupt mask per change flag |
| alarm_clr | input | 2 | Write-one-to-clear strobe per change flag |
| rt_data | output | 1 | Retimed data bit |
| rt_valid | output | 1 | One-cycle strobe for `rt_data` |
| loc_status | output | 1 | Loss of tributary clock |
| lofs_status | output | 1 | Loss of frame sync |
| alarm_delta | output | 2 | Sticky change flags |
| irq | output | 1 | Interrupt request |
| ais_sel | output | 2 | AIS request to the VT builder |

## Verification
Data is sent in both capture modes with the data level changing half a clock phase before the active edge. A design that samples on the wrong edge therefore returns the previous bit, and the scoreboard mismatches.

The clock is stopped for spans just short of and well past the loss limit. This separates a correct limit from one that is too short or too long.

Frame pulses are applied in several patterns:
- absent altogether;
- spaced exactly one period apart;
- spaced half a period apart;
- exact runs broken by a single miss.

These patterns distinguish a counter that misses the 3 and 6 thresholds from one that ignores misplaced pulses, and from one that lets the good and bad runs carry over across each other. Running with both alarms active checks which AIS code wins.

// File: rtl/trib_mon_pkg.sv
package trib_mon_pkg;

    localparam int NUM_ALM  = 2;
    localparam int ALM_LOC  = 0;
    localparam int ALM_LOFS = 1;

    typedef enum logic [1:0] {
        AIS_NONE    = 2'b00,
        AIS_PAYLOAD = 2'b01,
        AIS_FULL    = 2'b10
    } ais_kind_e;

    // bit 1: frame sync lost, bit 0: clock lost
    typedef struct packed {
        logic lofs;
        logic loc;
    } alarm_status_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_evt_t;

    function automatic ais_kind_e pick_ais(input alarm_status_t s);
        if (s.lofs)
            return AIS_FULL;
        else if (s.loc)
            return AIS_PAYLOAD;
        return AIS_NONE;
    endfunction

endpackage

// File: rtl/trib_edge_retimer.sv
module trib_edge_retimer
    import trib_mon_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cfg_rise_edge,
    input  logic      trib_clk,
    input  logic      trib_data,
    output edge_evt_t evt,
    output logic      rt_data,
    output logic      rt_valid
);

    localparam int TAP = SYNC_STAGES - 1;

    logic [SYNC_STAGES:0]   clk_pipe;
    logic [SYNC_STAGES-1:0] dat_pipe;
    logic                   take;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_pipe <= '0;
            dat_pipe <= '0;
        end else begin
            clk_pipe <= {clk_pipe[SYNC_STAGES-1:0], trib_clk};
            dat_pipe <= {dat_pipe[SYNC_STAGES-2:0], trib_data};
        end
    end

    always_comb begin
        evt.rise = clk_pipe[TAP] & ~clk_pipe[TAP+1];
        evt.fall = ~clk_pipe[TAP] & clk_pipe[TAP+1];
        take     = cfg_rise_edge ? evt.rise : evt.fall;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rt_data  <= 1'b0;
            rt_valid <= 1'b0;
        end else begin
            rt_valid <= take;
            if (take)
                rt_data <= dat_pipe[TAP];
        end
    end

    // R1: captures come one per edge of one polarity, never back to back
    assert_strobe_isolated_R1: assert property (@(posedge clk) disable iff (rst)
        rt_valid |=> !rt_valid);

endmodule

// File: rtl/trib_loc_detector.sv
module trib_loc_detector #(
    parameter int LOC_LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic edge_seen,
    output logic loc
);

    localparam int CW = $clog2(LOC_LIMIT + 1);

    logic [CW-1:0] quiet_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_cnt <= '0;
            loc       <= 1'b0;
        end else if (edge_seen) begin
            quiet_cnt <= '0;
            loc       <= 1'b0;
        end else if (quiet_cnt == CW'(LOC_LIMIT - 1)) begin
            loc       <= 1'b1;
        end else begin
            quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    assert_loc_clear_on_edge_R2: assert property (@(posedge clk) disable iff (rst)
        edge_seen |=> !loc);

    assert_loc_rise_when_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(loc) |-> $past(!edge_seen));

endmodule

// File: rtl/trib_frame_monitor.sv
module trib_frame_monitor #(
    parameter int FRAME_TICKS = 2430,
    parameter int GOOD_N      = 3,
    parameter int BAD_N       = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic byte_sync,
    input  logic trib_fs,
    output logic lofs
);

    localparam int PW = $clog2(FRAME_TICKS);
    localparam int GW = $clog2(GOOD_N + 1);
    localparam int BW = $clog2(BAD_N + 1);

    logic [PW-1:0] phase;
    logic [GW-1:0] good_run;
    logic [BW-1:0] bad_run;
    logic          at_slot;
    logic          good_evt;
    logic          bad_evt;

    always_comb begin
        at_slot  = (phase == PW'(FRAME_TICKS - 1));
        good_evt = trib_fs & at_slot;
        bad_evt  = trib_fs ^ at_slot;
    end

    always_ff @(posedge clk) begin
        if (rst || !byte_sync) begin
            phase    <= '0;
            good_run <= '0;
            bad_run  <= '0;
            lofs     <= 1'b0;
        end else begin
            if (trib_fs || at_slot)
                phase <= '0;
            else
                phase <= phase + 1'b1;

            if (good_evt) begin
                bad_run <= '0;
                if (good_run != GW'(GOOD_N))
                    good_run <= good_run + 1'b1;
                if (good_run == GW'(GOOD_N - 1))
                    lofs <= 1'b0;
            end else if (bad_evt) begin
                good_run <= '0;
                if (bad_run != BW'(BAD_N))
                    bad_run <= bad_run + 1'b1;
                if (bad_run == BW'(BAD_N - 1))
                    lofs <= 1'b1;
            end
        end
    end

    assert_idle_when_not_sync_R5: assert property (@(posedge clk) disable iff (rst)
        !byte_sync |=> !lofs);

    assert_runs_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        (good_run != '0) |-> (bad_run == '0));

    assert_loss_after_bad_run_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(lofs) |-> (int'($past(bad_run)) == BAD_N - 1));

    assert_gain_after_good_run_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(lofs) && $past(byte_sync) |-> (int'($past(good_run)) == GOOD_N - 1));

endmodule

// File: rtl/trib_alarm_reporter.sv
module trib_alarm_reporter
    import trib_mon_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  alarm_status_t      status,
    input  logic [NUM_ALM-1:0] mask,
    input  logic [NUM_ALM-1:0] clr,
    output logic [NUM_ALM-1:0] delta,
    output logic               irq,
    output ais_kind_e          ais_kind
);

    logic [NUM_ALM-1:0] cur;
    logic [NUM_ALM-1:0] prev;

    assign cur = status;

    always_ff @(posedge clk) begin
        if (rst)
            prev <= '0;
        else
            prev <= cur;
    end

    for (genvar g = 0; g < NUM_ALM; g++) begin : g_alm
        logic flag_q;

        always_ff @(posedge clk) begin
            if (rst)
                flag_q <= 1'b0;
            else
                flag_q <= (cur[g] ^ prev[g]) | (flag_q & ~clr[g]);
        end

        assign delta[g] = flag_q;

        assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (rst)
            (flag_q && !clr[g]) |=> flag_q);

        assert_change_sets_flag_R3: assert property (@(posedge clk) disable iff (rst)
            (cur[g] != $past(cur[g])) |=> flag_q);
    end

    always_comb begin
        irq      = |(delta & ~mask);
        ais_kind = pick_ais(status);
    end

    assert_irq_needs_flag_R4: assert property (@(posedge clk) disable iff (rst)
        irq |-> (delta != '0));

endmodule

// File: rtl/trib_input_monitor.sv
module trib_input_monitor
    import trib_mon_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LOC_LIMIT   = 16,
    parameter int FRAME_TICKS = 2430,
    parameter int GOOD_N      = 3,
    parameter int BAD_N       = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_rise_edge,
    input  logic       cfg_byte_sync,
    input  logic       trib_clk,
    input  logic       trib_data,
    input  logic       trib_fs,
    input  logic [1:0] alarm_mask,
    input  logic [1:0] alarm_clr,
    output logic       rt_data,
    output logic       rt_valid,
    output logic       loc_status,
    output logic       lofs_status,
    output logic [1:0] alarm_delta,
    output logic       irq,
    output logic [1:0] ais_sel
);

    edge_evt_t     evt;
    alarm_status_t status;
    ais_kind_e     ais_kind;
    logic          loc_w;
    logic          lofs_w;

    trib_edge_retimer #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_retimer (
        .clk          (clk),
        .rst          (rst),
        .cfg_rise_edge(cfg_rise_edge),
        .trib_clk     (trib_clk),
        .trib_data    (trib_data),
        .evt          (evt),
        .rt_data      (rt_data),
        .rt_valid     (rt_valid)
    );

    trib_loc_detector #(
        .LOC_LIMIT(LOC_LIMIT)
    ) u_loc (
        .clk      (clk),
        .rst      (rst),
        .edge_seen(evt.rise | evt.fall),
        .loc      (loc_w)
    );

    trib_frame_monitor #(
        .FRAME_TICKS(FRAME_TICKS),
        .GOOD_N     (GOOD_N),
        .BAD_N      (BAD_N)
    ) u_frame (
        .clk      (clk),
        .rst      (rst),
        .byte_sync(cfg_byte_sync),
        .trib_fs  (trib_fs),
        .lofs     (lofs_w)
    );

    always_comb begin
        status.loc  = loc_w;
        status.lofs = lofs_w;
    end

    trib_alarm_reporter u_report (
        .clk     (clk),
        .rst     (rst),
        .status  (status),
        .mask    (alarm_mask),
        .clr     (alarm_clr),
        .delta   (alarm_delta),
        .irq     (irq),
        .ais_kind(ais_kind)
    );

    assign loc_status  = loc_w;
    assign lofs_status = lofs_w;
    assign ais_sel     = ais_kind;

    // R9: the full-VT request never appears without a frame alarm
    assert_full_ais_needs_lofs_R9: assert property (@(posedge clk) disable iff (rst)
        (ais_sel == 2'b10) |-> lofs_status);

endmodule

// File: tb/trib_input_monitor_tb.sv
module trib_input_monitor_tb;

    localparam int P = 40;
    localparam int Q = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_rise_edge = 1'b1;
    logic       cfg_byte_sync = 1'b0;
    logic       trib_clk = 1'b0;
    logic       trib_data = 1'b0;
    logic       trib_fs = 1'b0;
    logic [1:0] alarm_mask = 2'b00;
    logic [1:0] alarm_clr = 2'b00;
    logic       rt_data;
    logic       rt_valid;
    logic       loc_status;
    logic       lofs_status;
    logic [1:0] alarm_delta;
    logic       irq;
    logic [1:0] ais_sel;

    int n_chk  = 0;
    int n_fail = 0;
    logic exp_q[$];

    always #5 clk = ~clk;

    trib_input_monitor #(
        .LOC_LIMIT  (16),
        .FRAME_TICKS(P)
    ) u_dut (
        .clk          (clk),
        .rst          (rst),
        .cfg_rise_edge(cfg_rise_edge),
        .cfg_byte_sync(cfg_byte_sync),
        .trib_clk     (trib_clk),
        .trib_data    (trib_data),
        .trib_fs      (trib_fs),
        .alarm_mask   (alarm_mask),
        .alarm_clr    (alarm_clr),
        .rt_data      (rt_data),
        .rt_valid     (rt_valid),
        .loc_status   (loc_status),
        .lofs_status  (lofs_status),
        .alarm_delta  (alarm_delta),
        .irq          (irq),
        .ais_sel      (ais_sel)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // driver: one tributary bit, data moves half a phase before the active edge
    task automatic drive_bit(input logic b);
        if (cfg_rise_edge) begin
            trib_clk = 1'b0;
            repeat (Q) @(negedge clk);
            trib_data = b;
            repeat (Q) @(negedge clk);
            trib_clk = 1'b1;
        end else begin
            trib_clk = 1'b1;
            repeat (Q) @(negedge clk);
            trib_data = b;
            repeat (Q) @(negedge clk);
            trib_clk = 1'b0;
        end
        exp_q.push_back(b);
        repeat (2 * Q) @(negedge clk);
    endtask

    task automatic fs_train(input int count, input int spacing);
        for (int i = 0; i < count; i++) begin
            trib_fs = 1'b1;
            @(negedge clk);
            trib_fs = 1'b0;
            repeat (spacing - 1) @(negedge clk);
        end
    endtask

    task automatic clear_flags(input logic [1:0] which);
        alarm_clr = which;
        @(negedge clk);
        alarm_clr = 2'b00;
        @(negedge clk);
    endtask

    // monitor: pops the scoreboard on every retimed strobe
    always @(negedge clk) begin : mon
        logic b;
        if (!rst && rt_valid) begin
            if (exp_q.size() == 0) begin
                chk("R1 unexpected capture", 1, 0);
            end else begin
                b = exp_q.pop_front();
                chk("R1 retimed bit", int'(rt_data), int'(b));
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [11:0] pat_a;
        logic [11:0] pat_b;
        pat_a = 12'hB4D;
        pat_b = 12'h5A3;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R10 reset state
        chk("R10 rt_valid", rt_valid, 0);
        chk("R10 loc", loc_status, 0);
        chk("R10 lofs", lofs_status, 0);
        chk("R10 delta", alarm_delta, 0);
        chk("R10 irq", irq, 0);
        chk("R10 ais_sel", ais_sel, 0);

        // R1 rising-edge capture, then falling-edge capture
        cfg_rise_edge = 1'b1;
        for (int i = 11; i >= 0; i--) drive_bit(pat_a[i]);
        cfg_rise_edge = 1'b0;
        for (int i = 11; i >= 0; i--) drive_bit(pat_b[i]);
        chk("R1 queue drained", exp_q.size(), 0);

        // R2 loss of clock: about 10 quiet cycles so far, not yet declared
        clear_flags(2'b11);
        chk("R2 loc before limit", loc_status, 0);
        chk("R3 flags cleared", alarm_delta, 0);
        repeat (12) @(negedge clk);
        chk("R2 loc after limit", loc_status, 1);
        chk("R9 payload AIS", ais_sel, 1);
        chk("R3 loc flag set", alarm_delta, 1);
        chk("R4 irq unmasked", irq, 1);
        alarm_mask = 2'b01;
        @(negedge clk);
        chk("R4 irq masked", irq, 0);
        alarm_mask = 2'b00;
        @(negedge clk);
        chk("R4 irq unmasked again", irq, 1);
        clear_flags(2'b01);
        chk("R3 clear while alarm holds", alarm_delta, 0);
        chk("R4 irq after clear", irq, 0);
        chk("R2 loc still high", loc_status, 1);
        drive_bit(1'b1);
        chk("R2 loc cleared by edge", loc_status, 0);
        chk("R3 flag on clear", alarm_delta, 1);
        chk("R9 no AIS", ais_sel, 0);
        clear_flags(2'b11);

        // R8 missing pulses: five not enough, six declares loss
        cfg_byte_sync = 1'b1;
        repeat (6 * P - P / 2) @(negedge clk);
        chk("R8 five misses", lofs_status, 0);
        chk("R9 payload AIS before frame loss", ais_sel, 1);
        repeat (P) @(negedge clk);
        chk("R8 six misses", lofs_status, 1);
        chk("R2 loc during frame test", loc_status, 1);
        chk("R9 AIS-V priority", ais_sel, 2);
        chk("R3 lofs flag", alarm_delta[1], 1);
        alarm_mask = 2'b01;
        @(negedge clk);
        chk("R4 lofs flag unmasked", irq, 1);
        alarm_mask = 2'b11;
        @(negedge clk);
        chk("R4 all masked", irq, 0);
        alarm_mask = 2'b00;
        clear_flags(2'b11);

        // R7 acquisition: anchor (mismatch) + two valid, then third valid
        fs_train(3, P);
        chk("R7 two valid pulses", lofs_status, 1);
        fs_train(1, P);
        chk("R7 third valid pulse", lofs_status, 0);
        chk("R9 back to payload AIS", ais_sel, 1);

        // R6 misplaced pulses: one miss plus misplaced pulses
        repeat (P / 4) @(negedge clk);
        fs_train(4, P / 2);
        chk("R6 five mismatches", lofs_status, 0);
        fs_train(1, P / 2);
        chk("R6 sixth mismatch", lofs_status, 1);

        // R6 valid run broken by a mismatch starts over
        fs_train(3, P);
        repeat (P / 4) @(negedge clk);
        fs_train(3, P);
        chk("R6 broken valid run", lofs_status, 1);
        fs_train(1, P);
        chk("R7 acquire after break", lofs_status, 0);

        // R5 mode off forces the monitor idle
        repeat (6 * P + P / 2) @(negedge clk);
        chk("R8 loss again", lofs_status, 1);
        cfg_byte_sync = 1'b0;
        repeat (2) @(negedge clk);
        chk("R5 idle clears loss", lofs_status, 0);
        fs_train(8, P / 2);
        repeat (7 * P) @(negedge clk);
        chk("R5 pulses ignored", lofs_status, 0);
        chk("R9 payload only", ais_sel, 1);
        chk("R1 no stray capture", exp_q.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule